// File: doc/BRIEF.md
# Memory Error Status Register

This block records the most recent memory parity error and raises an interrupt for it. It is reached through a byte-addressed window of five bytes. Offset 0 holds a control and status byte. Offsets 1 to 4 hold the 32-bit address of the failing access, most significant byte first. An access names a start offset and a length of 1 to 4 bytes. Data travels left-justified on a 32-bit bus, so the first byte of the access sits in bits 31:24.

A separate capture port loads an error: it sets the interrupt-active flag, the four per-lane parity flags and the stored address. Software cannot write these status bits. It clears them, together with the stored address, by writing any access whose range includes offset 1, the leading address byte. Software also owns three control bits: interrupt enable, parity-check enable and parity-test mode. Turning test mode on sends a one-cycle request to invalidate every TLB entry. The interrupt output is a level that is high exactly while an error is active and interrupts are enabled.

Top module: `memerr_status_reg`

## Requirements
- R1: After reset the status byte, the stored address, `irq_o` and `tlb_flush_o` are all zero.
- R2: Reading at offset `o` returns window bytes `o`..`o+3` on `rd_data[31:24]`..`rd_data[7:0]`. Window byte 0 is the status byte and bytes 1..4 are address bits 31:24, 23:16, 15:8 and 7:0. Bytes past offset 4 read as zero.
- R3: Status byte layout: bit 7 is error active, bit 6 is interrupt enable, bit 5 is parity-check enable, bit 4 is test mode and bits 3:0 are the parity flags for lanes 3..0. A write whose range includes offset 0 loads bits 6:4 from its byte for offset 0 and leaves bits 7 and 3:0 unchanged.
- R4: A write whose range includes offset 1 clears bits 7 and 3:0 and zeroes the stored address in the same cycle. Bits 6:4 are unchanged unless the same write also covers offset 0.
- R5: A write that covers only offsets 2 to 4 changes neither the address nor the status byte.
- R6: A capture loads bit 7 with one, bits 3:0 with `cap_lanes` and the stored address with `cap_addr`, and keeps bits 6:4. The result is readable after the capturing clock edge.
- R7: A capture in the same cycle as an unlatching or status-writing access wins for bits 7, 3:0 and the address. Bits 6:4 still take the written value.
- R8: `irq_o` equals bit 7 AND bit 6 of the status byte in every cycle after reset. It changes only when that product changes.
- R9: `tlb_flush_o` is high for exactly the one cycle after the edge at which bit 4 went from 0 to 1. It stays low when bit 4 is rewritten as 1 or cleared.
- R10: Reads, accesses with `req_valid` low, and writes of length 0 or longer than 4 bytes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 3 | Start byte offset in the window |
| req_size | input | 3 | Access length in bytes (1..4 valid) |
| wr_data | input | 32 | Write bytes, first byte in bits 31:24 |
| rd_data | output | 32 | Read bytes from `req_off`, first in bits 31:24 |
| cap_valid | input | 1 | Capture a new error |
| cap_lanes | input | 4 | Failing byte lanes of the captured error |
| cap_addr | input | 32 | Address of the captured error |
| irq_o | output | 1 | Level interrupt |
| tlb_flush_o | output | 1 | One-cycle invalidate-all-TLB request |

## Verification
The assertions are checked on every cycle. They cover:
- the interrupt level against the status bits, and that the level moves only on a computed change;
- that the read-only bits hold across a status write;
- that an unlatch clears the status and address;
- that a capture beats a concurrent unlatch;
- the shape of the flush pulse.

Only the bench scenarios can show the byte placement in the window, the big-endian address layout, the zero fill past the window, and the rule that writes of other lengths or only to the trailing address bytes are ignored. The bench sweeps every start offset and length under several data patterns against its own arithmetic model.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int BIT_ACT = 7;
  localparam int BIT_IEN = 6;
  localparam int BIT_TST = 4;
  localparam logic [7:0] WR_MASK = 8'h70;
  localparam logic [7:0] RO_MASK = 8'h8F;

  // true when window byte idx lies inside an access of size bytes from off
  function automatic logic covers(input int off, input int size, input int idx);
    return (idx >= off) && (idx < off + size);
  endfunction

  // status byte after a software write of wbyte
  function automatic logic [7:0] merge_write(input logic [7:0] cur, input logic [7:0] wbyte);
    return (cur & RO_MASK) | (wbyte & WR_MASK);
  endfunction

  // status byte after an error capture
  function automatic logic [7:0] merge_capture(input logic [7:0] cur, input logic [3:0] lanes);
    return (cur & WR_MASK) | 8'h80 | {4'h0, lanes};
  endfunction
endpackage

// File: rtl/memerr_win.sv
module memerr_win
  import memerr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ACC_BYTES = 4,
  parameter int OFF_W     = 3,
  parameter int SZ_W      = 3
) (
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [SZ_W-1:0]        req_size,
  input  logic [ACC_BYTES*8-1:0] wr_data,
  input  logic [7:0]             st_q,
  input  logic [ADDR_W-1:0]      addr_q,
  output logic                   csr_we,
  output logic [7:0]             csr_wbyte,
  output logic                   unlatch,
  output logic [ACC_BYTES*8-1:0] rd_data
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int WIN        = 1 + ADDR_BYTES;

  logic [7:0] win [WIN];
  logic       wr_ok;

  assign win[0] = st_q;
  generate
    for (genvar j = 0; j < ADDR_BYTES; j++) begin : g_addr_bytes
      assign win[1+j] = addr_q[(ADDR_BYTES-1-j)*8 +: 8];
    end
  endgenerate

  assign wr_ok = req_valid && req_write && (int'(req_size) <= ACC_BYTES);

  always_comb begin
    csr_we    = 1'b0;
    csr_wbyte = 8'h00;
    unlatch   = 1'b0;
    for (int k = 0; k < ACC_BYTES; k++) begin
      if (wr_ok && covers(int'(req_off), int'(req_size), int'(req_off) + k)) begin
        if (int'(req_off) + k == 0) begin
          csr_we    = 1'b1;
          csr_wbyte = wr_data[(ACC_BYTES-1-k)*8 +: 8];
        end
        if (int'(req_off) + k == 1) unlatch = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < ACC_BYTES; k++) begin
      for (int i = 0; i < WIN; i++) begin
        if (int'(req_off) + k == i) rd_data[(ACC_BYTES-1-k)*8 +: 8] = win[i];
      end
    end
  end
endmodule

// File: rtl/memerr_core.sv
module memerr_core
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [7:0]        csr_wbyte,
  input  logic              unlatch,
  input  logic              cap_valid,
  input  logic [3:0]        cap_lanes,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [7:0]        st_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        st_nxt,
  output logic              tlb_flush_o
);
  logic [ADDR_W-1:0] addr_nxt;
  logic              ev_test_rise;
  logic              flush_q;

  always_comb begin
    st_nxt   = st_q;
    addr_nxt = addr_q;
    if (csr_we) st_nxt = merge_write(st_nxt, csr_wbyte);
    if (unlatch) begin
      st_nxt   = st_nxt & WR_MASK;
      addr_nxt = '0;
    end
    if (cap_valid) begin
      st_nxt   = merge_capture(st_nxt, cap_lanes);
      addr_nxt = cap_addr;
    end
  end

  assign ev_test_rise = st_nxt[BIT_TST] & ~st_q[BIT_TST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      addr_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      addr_q  <= addr_nxt;
      flush_q <= ev_test_rise;
    end
  end

  assign tlb_flush_o = flush_q;

  // R3: status write alone never moves read-only bits
  a_r3_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !unlatch && !cap_valid) |=> ((st_q & RO_MASK) == ($past(st_q) & RO_MASK)));

  // R4: unlatch without capture clears status flags and address
  a_r4_unlatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (unlatch && !cap_valid) |=> (addr_q == '0 && (st_q & RO_MASK) == 8'h00));

  // R7: capture wins over a concurrent unlatch
  a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> (st_q[BIT_ACT] && addr_q == $past(cap_addr)));

  // R9: pulse only after a rise of the test bit, and lasts one cycle
  a_r9_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |-> (st_q[BIT_TST] && !$past(st_q[BIT_TST])));
  a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |=> !tlb_flush_o);
endmodule

// File: rtl/memerr_irq.sv
module memerr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_nxt,
  output logic irq_o
);
  logic irq_q;
  logic ev_change;

  assign ev_change = lvl_nxt ^ irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (ev_change) irq_q <= lvl_nxt;
  end

  assign irq_o = irq_q;

  // R8: the output level moves only on a computed change
  a_r8_change_only: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != $past(irq_o)) |-> $past(ev_change));
endmodule

// File: rtl/memerr_status_reg.sv
module memerr_status_reg
  import memerr_pkg::*;
#(
  parameter  int ADDR_W    = 32,
  parameter  int ACC_BYTES = 4,
  localparam int WIN       = 1 + ADDR_W / 8,
  localparam int OFF_W     = $clog2(WIN),
  localparam int SZ_W      = $clog2(ACC_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [SZ_W-1:0]        req_size,
  input  logic [ACC_BYTES*8-1:0] wr_data,
  output logic [ACC_BYTES*8-1:0] rd_data,
  input  logic                   cap_valid,
  input  logic [3:0]             cap_lanes,
  input  logic [ADDR_W-1:0]      cap_addr,
  output logic                   irq_o,
  output logic                   tlb_flush_o
);
  logic              csr_we;
  logic [7:0]        csr_wbyte;
  logic              unlatch;
  logic [7:0]        st_q;
  logic [7:0]        st_nxt;
  logic [ADDR_W-1:0] addr_q;

  memerr_win #(
    .ADDR_W(ADDR_W), .ACC_BYTES(ACC_BYTES), .OFF_W(OFF_W), .SZ_W(SZ_W)
  ) u_win (
    .req_valid(req_valid), .req_write(req_write), .req_off(req_off),
    .req_size(req_size), .wr_data(wr_data), .st_q(st_q), .addr_q(addr_q),
    .csr_we(csr_we), .csr_wbyte(csr_wbyte), .unlatch(unlatch), .rd_data(rd_data)
  );

  memerr_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wbyte(csr_wbyte),
    .unlatch(unlatch), .cap_valid(cap_valid), .cap_lanes(cap_lanes),
    .cap_addr(cap_addr), .st_q(st_q), .addr_q(addr_q), .st_nxt(st_nxt),
    .tlb_flush_o(tlb_flush_o)
  );

  memerr_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .lvl_nxt(st_nxt[BIT_ACT] & st_nxt[BIT_IEN]),
    .irq_o(irq_o)
  );

  // R8: interrupt level tracks active AND enable
  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (st_q[BIT_ACT] & st_q[BIT_IEN]));
endmodule

// File: tb/memerr_status_reg_tb.sv
module memerr_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_off = '0, req_size = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cap_valid = 1'b0;
  logic [3:0]  cap_lanes = '0;
  logic [31:0] cap_addr = '0;
  logic        irq_o, tlb_flush_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  logic [7:0]  m_st = '0;
  logic [31:0] m_addr = '0;
  logic        m_flush = 1'b0;

  always #4 clk = ~clk;

  memerr_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_size(req_size), .wr_data(wr_data), .rd_data(rd_data),
    .cap_valid(cap_valid), .cap_lanes(cap_lanes), .cap_addr(cap_addr),
    .irq_o(irq_o), .tlb_flush_o(tlb_flush_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] win_byte(input int i);
    if (i == 0) return m_st;
    if (i >= 1 && i <= 4) return m_addr[(4-i)*8 +: 8];
    return 8'h00;
  endfunction

  // sits in the low half of the clock, drives reads only
  task automatic check_all(input string req);
    check({req, " irq R8"}, {31'd0, irq_o}, {31'd0, m_st[7] & m_st[6]});
    check({req, " flush R9"}, {31'd0, tlb_flush_o}, {31'd0, m_flush});
    for (int o = 0; o < 5; o += 2) begin
      req_off = o[2:0];
      #0.5;
      check({req, " read R2"}, rd_data,
            {win_byte(o), win_byte(o+1), win_byte(o+2), win_byte(o+3)});
    end
  endtask

  // one access cycle; starts and ends at a negative edge
  task automatic op(input logic v, input logic w, input int off, input int sz,
                    input logic [31:0] d, input logic cv, input logic [3:0] ln,
                    input logic [31:0] ca, input string req);
    logic [7:0] old_st;
    logic       unl;
    req_valid = v; req_write = w; req_off = off[2:0]; req_size = sz[2:0];
    wr_data = d; cap_valid = cv; cap_lanes = ln; cap_addr = ca;
    @(posedge clk);
    old_st = m_st;
    unl = 1'b0;
    if (v && w && sz <= 4) begin
      for (int k = 0; k < sz; k++) begin
        if (off + k == 0) m_st = (m_st & 8'h8F) | (d[31-8*k -: 8] & 8'h70);
        if (off + k == 1) unl = 1'b1;
      end
    end
    if (unl) begin m_st = m_st & 8'h70; m_addr = '0; end
    if (cv) begin m_st = (m_st & 8'h70) | 8'h80 | {4'h0, ln}; m_addr = ca; end
    m_flush = m_st[4] & ~old_st[4];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; cap_valid = 1'b0;
    check_all(req);
  endtask

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hC3A5_5A3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    for (int p = 0; p < 3; p++) begin
      for (int off = 0; off < 5; off++) begin
        for (int sz = 0; sz < 7; sz++) begin
          op(1, 1, 0, 0, 0, 1, 4'(off + sz + p), 32'h8100_0000 + 32'(off*16 + sz),
             "R6 capture");
          op(1, 1, off, sz, pats[p], 0, 0, 0, "R3 R4 R5 R10 sweep");
        end
      end
    end

    // R10: reads and unstrobed writes leave state alone
    op(1, 1, 0, 1, 32'hF000_0000, 1, 4'hA, 32'hDEAD_BEEF, "R7 capture with status write");
    op(1, 0, 0, 4, 32'h0000_0000, 0, 0, 0, "R10 read no effect");
    op(0, 1, 0, 4, 32'h0000_0000, 0, 0, 0, "R10 no strobe");
    op(1, 1, 0, 1, 32'h5000_0000, 0, 0, 0, "R9 test already set");
    // R7: capture and unlatch in the same cycle
    op(1, 1, 0, 2, 32'h4000_0000, 1, 4'h5, 32'h0BAD_F00D, "R7 capture beats unlatch");
    op(1, 1, 2, 3, 32'h1122_3300, 0, 0, 0, "R5 trailing address bytes");
    op(1, 1, 1, 1, 32'h0000_0000, 0, 0, 0, "R4 unlatch single byte");
    op(1, 1, 0, 1, 32'h0000_0000, 0, 0, 0, "R9 test cleared");
    op(1, 1, 0, 1, 32'h1000_0000, 0, 0, 0, "R9 test rise");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule